// File: doc/BRIEF.md
# Flash Chip-Erase Command Sequencer

This block models the command side of a parallel NOR flash device for one operation: erasing the whole array. It samples a simple bus (chip enable, write enable, output enable, address, command byte) once per clock and treats every clock cycle with chip enable and write enable both low as one write. When six writes arrive in the one accepted order, the block starts an internal erase routine that needs no further help from the host. The routine first fills the array with zeros and checks them, then waits a parameterised erase time, and finally sets every word to all ones.

While the routine runs, the ready/busy output is low and reads return a status word instead of array data. In that word one bit is held low and two bits flip on every read, so the host can poll for completion. Writes that arrive in this period have no effect. A hardware reset input aborts the routine at once and leaves the array partly processed. A separate power-on reset also loads the array with a known fill pattern. The array is a small register file, and one word is written per clock.

Top module: `flash_chip_erase`

## Requirements
- R1: After power-on reset, ry_by_n is 1 and array word i holds ((i*0x0301) XOR 0x5A5A) truncated to DW bits. A read (ce_n=0, oe_n=0, we_n=1) of word addr[AW-1:0] shows on rdata after the next clock edge.
- R2: Erase starts only after six writes (ce_n=0, we_n=0), matched on the full address and on wdata, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10. ry_by_n is 0 from the clock edge that takes the sixth write.
- R3: A write that does not match the expected step returns the chain to its start and is not itself counted as a first step. For example, 0x30 in place of 0x10 on the sixth write starts nothing.
- R4: ry_by_n stays 0 for exactly 3*2^AW + ERASE_CYCLES clock cycles and then returns to 1.
- R5: The routine writes zero to words 0, 1, 2, … in ascending order, one word per clock from the first busy edge. It checks all of them before the erase phase.
- R6: After a completed erase every word reads 0xFFFF, and reads return array data again.
- R7: A read while busy returns a status word. Bit 7 is 0, bits 6 and 2 both invert on every status read, and all other bits are 0.
- R8: Writes while busy are ignored and do not advance the six-write chain.
- R9: Driving hw_rst_n low aborts the erase: ry_by_n is 1 at once, words already processed keep their new value, the rest keep their old value, and a partly entered chain is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also loads the array fill pattern |
| hw_rst_n | input | 1 | Hardware reset, active low; aborts the erase and clears the chain |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | BUS_AW | Bus address |
| wdata | input | 8 | Command byte |
| rdata | output | DW | Registered read data or status word |
| ry_by_n | output | 1 | Ready (1) / busy (0) |

## Verification
ry_by_n falls at the clock edge that takes the sixth write, so the bench checks it at the falling edge just after that write. It rises exactly 3*2^AW + ERASE_CYCLES edges later. The bench counts clock edges from the start and checks ry_by_n one cycle before that point and at it. Read data is registered, so each read is sampled at the falling edge after the rising edge that captures it. A hardware reset acts asynchronously, so ry_by_n is checked 1 ns after hw_rst_n falls. The abort case zeroes exactly ten words, because the bench lets ten edges of preprogramming pass before pulling reset.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_S1,
        CH_S2,
        CH_S3,
        CH_S4,
        CH_S5
    } chain_e;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_PREP,
        EN_VERIFY,
        EN_WAIT,
        EN_ERASE
    } eng_e;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_WIPE   = 8'h10;

endpackage

// File: rtl/cmd_chain.sv
module cmd_chain
    import fce_pkg::*;
#(
    parameter int BUS_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              busy_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              start_o
);

    typedef struct packed {
        chain_e step;
    } chain_t;

    chain_t cur_q, cur_d;
    logic [BUS_AW-1:0] want_addr;
    logic [7:0]        want_data;
    logic              hit;

    always_comb begin
        want_addr = BUS_AW'(KEY_ADDR_A);
        want_data = KEY_DATA_A;
        case (cur_q.step)
            CH_IDLE: begin want_addr = BUS_AW'(KEY_ADDR_A); want_data = KEY_DATA_A; end
            CH_S1:   begin want_addr = BUS_AW'(KEY_ADDR_B); want_data = KEY_DATA_B; end
            CH_S2:   begin want_addr = BUS_AW'(KEY_ADDR_A); want_data = CMD_SETUP;  end
            CH_S3:   begin want_addr = BUS_AW'(KEY_ADDR_A); want_data = KEY_DATA_A; end
            CH_S4:   begin want_addr = BUS_AW'(KEY_ADDR_B); want_data = KEY_DATA_B; end
            CH_S5:   begin want_addr = BUS_AW'(KEY_ADDR_A); want_data = CMD_WIPE;   end
            default: begin want_addr = BUS_AW'(KEY_ADDR_A); want_data = KEY_DATA_A; end
        endcase
        hit = (addr_i == want_addr) && (data_i == want_data);
    end

    always_comb begin
        cur_d   = cur_q;
        start_o = 1'b0;
        if (busy_i) begin
            cur_d.step = CH_IDLE;
        end else if (wr_i) begin
            if (!hit) begin
                cur_d.step = CH_IDLE;
            end else begin
                case (cur_q.step)
                    CH_IDLE: cur_d.step = CH_S1;
                    CH_S1:   cur_d.step = CH_S2;
                    CH_S2:   cur_d.step = CH_S3;
                    CH_S3:   cur_d.step = CH_S4;
                    CH_S4:   cur_d.step = CH_S5;
                    CH_S5: begin
                        cur_d.step = CH_IDLE;
                        start_o    = 1'b1;
                    end
                    default: cur_d.step = CH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.step <= CH_IDLE;
        end else begin
            cur_q <= cur_d;
        end
    end

    // R8: the chain never holds progress while the routine runs
    a_r8_busy_clears_chain: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (cur_q.step == CH_IDLE));

    // R3: a mismatching write always lands the chain at its start
    a_r3_miss_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !busy_i && !hit) |=> (cur_q.step == CH_IDLE));

endmodule

// File: rtl/erase_engine.sv
module erase_engine
    import fce_pkg::*;
#(
    parameter int AW           = 6,
    parameter int DW           = 16,
    parameter int ERASE_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          busy_o
);

    localparam int CW = $clog2(ERASE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(ERASE_CYCLES - 1);

    typedef struct packed {
        eng_e          state;
        logic [AW-1:0] idx;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t cur_q, cur_d;
    logic last_word;

    assign last_word   = &cur_q.idx;
    assign mem_addr_o  = cur_q.idx;
    assign busy_o      = (cur_q.state != EN_IDLE);

    always_comb begin
        cur_d       = cur_q;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        case (cur_q.state)
            EN_IDLE: begin
                if (start_i) begin
                    cur_d.state = EN_PREP;
                    cur_d.idx   = '0;
                end
            end
            EN_PREP: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = '0;
                if (last_word) begin
                    cur_d.state = EN_VERIFY;
                    cur_d.idx   = '0;
                end else begin
                    cur_d.idx = cur_q.idx + 1'b1;
                end
            end
            EN_VERIFY: begin
                if (rd_data_i != '0) begin
                    cur_d.state = EN_PREP;
                end else if (last_word) begin
                    cur_d.state = EN_WAIT;
                    cur_d.cnt   = '0;
                end else begin
                    cur_d.idx = cur_q.idx + 1'b1;
                end
            end
            EN_WAIT: begin
                if (cur_q.cnt == CNT_LAST) begin
                    cur_d.state = EN_ERASE;
                    cur_d.idx   = '0;
                end else begin
                    cur_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            EN_ERASE: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = '1;
                if (last_word) begin
                    cur_d.state = EN_IDLE;
                    cur_d.idx   = '0;
                end else begin
                    cur_d.idx = cur_q.idx + 1'b1;
                end
            end
            default: cur_d.state = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= EN_IDLE;
            cur_q.idx   <= '0;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    // R2: a start seen while idle enters preprogramming next cycle
    a_r2_start_enters_prep: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cur_q.state == EN_IDLE) |=> (cur_q.state == EN_PREP && cur_q.idx == '0));

    // R5: preprogramming walks the words in ascending order
    a_r5_prep_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == EN_PREP && !last_word) |=>
        (cur_q.state == EN_PREP && cur_q.idx == $past(cur_q.idx) + 1'b1));

    // R5: the erase wait is only entered after a clean verify of the top word
    a_r5_verify_before_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.state == EN_WAIT) |-> ($past(cur_q.state) == EN_VERIFY && $past(rd_data_i) == '0));

    // R4: the routine ends right after the last erased word
    a_r4_erase_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == EN_ERASE && last_word) |=> (cur_q.state == EN_IDLE));

endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    function automatic logic [DW-1:0] fill_word(int unsigned i);
        logic [31:0] t;
        t = (32'(i) * 32'h0000_0301) ^ 32'h0000_5A5A;
        return DW'(t);
    endfunction

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= fill_word(i);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // R1: the array only changes on a write strobe
    a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!por_n)
        !we_i |=> (mem_q[$past(raddr_a_i)] == $past(rdata_a_o)));

endmodule

// File: rtl/flash_chip_erase.sv
module flash_chip_erase
    import fce_pkg::*;
#(
    parameter int AW           = 6,
    parameter int DW           = 16,
    parameter int BUS_AW       = 11,
    parameter int ERASE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [DW-1:0]     rdata,
    output logic              ry_by_n
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          tog;
    } rd_t;

    logic          rst_n;
    logic          wr_cyc;
    logic          rd_cyc;
    logic          start;
    logic          busy;
    logic [AW-1:0] eng_addr;
    logic          eng_we;
    logic [DW-1:0] eng_wdata;
    logic [DW-1:0] bus_word;
    logic [DW-1:0] eng_word;
    rd_t           rd_q, rd_d;

    assign rst_n  = por_n & hw_rst_n;
    assign wr_cyc = !ce_n && !we_n;
    assign rd_cyc = !ce_n && !oe_n && we_n;

    cmd_chain #(
        .BUS_AW (BUS_AW)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_cyc),
        .busy_i  (busy),
        .addr_i  (addr),
        .data_i  (wdata),
        .start_o (start)
    );

    erase_engine #(
        .AW           (AW),
        .DW           (DW),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .rd_data_i   (eng_word),
        .mem_addr_o  (eng_addr),
        .mem_we_o    (eng_we),
        .mem_wdata_o (eng_wdata),
        .busy_o      (busy)
    );

    flash_array #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .clk       (clk),
        .por_n     (por_n),
        .we_i      (eng_we),
        .waddr_i   (eng_addr),
        .wdata_i   (eng_wdata),
        .raddr_a_i (addr[AW-1:0]),
        .rdata_a_o (bus_word),
        .raddr_b_i (eng_addr),
        .rdata_b_o (eng_word)
    );

    function automatic logic [DW-1:0] status_word(logic t);
        logic [DW-1:0] s;
        s    = '0;
        s[7] = 1'b0;
        s[6] = t;
        s[2] = t;
        return s;
    endfunction

    always_comb begin
        rd_d = rd_q;
        if (rd_cyc) begin
            if (busy) begin
                rd_d.tog  = ~rd_q.tog;
                rd_d.data = status_word(~rd_q.tog);
            end else begin
                rd_d.data = bus_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.data <= '0;
            rd_q.tog  <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata   = rd_q.data;
    assign ry_by_n = !busy;

    // R2: an accepted sixth write drives ready/busy low on the next edge
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ry_by_n);

    // R7: status reads show bit 7 low
    a_r7_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && busy) |=> (rdata[7] == 1'b0));

    // R7: every status read flips the toggle bits
    a_r7_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && busy) |=> (rdata[6] != $past(rd_q.tog) && rdata[2] == rdata[6]));

    // R6: reads while ready return array contents
    a_r6_ready_reads_array: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && !busy) |=> (rdata == $past(bus_word)));

endmodule

// File: tb/flash_chip_erase_test.sv
module flash_chip_erase_test;

    localparam int AW           = 6;
    localparam int DEPTH        = 1 << AW;
    localparam int DW           = 16;
    localparam int BUS_AW       = 11;
    localparam int ERASE_CYCLES = 200;
    localparam int BUSY_LEN     = 3 * DEPTH + ERASE_CYCLES;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              hw_rst_n = 1'b1;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [BUS_AW-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [DW-1:0]     rdata;
    logic              ry_by_n;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_chip_erase #(
        .AW (AW), .DW (DW), .BUS_AW (BUS_AW), .ERASE_CYCLES (ERASE_CYCLES)
    ) uut (
        .clk (clk), .por_n (por_n), .hw_rst_n (hw_rst_n), .ce_n (ce_n),
        .we_n (we_n), .oe_n (oe_n), .addr (addr), .wdata (wdata),
        .rdata (rdata), .ry_by_n (ry_by_n)
    );

    function automatic logic [DW-1:0] fill(int i);
        logic [31:0] t;
        t = (32'(i) * 32'h0301) ^ 32'h5A5A;
        return t[DW-1:0];
    endfunction

    function automatic logic [BUS_AW-1:0] step_addr(int k);
        return (k == 1 || k == 4) ? BUS_AW'(11'h2AA) : BUS_AW'(11'h555);
    endfunction

    function automatic logic [7:0] step_data(int k);
        case (k)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [BUS_AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(logic [BUS_AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic send_steps(int from, int upto);
        for (int k = from; k <= upto; k++) bus_write(step_addr(k), step_data(k));
    endtask

    task automatic check_array(string req);
        logic [DW-1:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(BUS_AW'(i), v);
            check(v == exp_mem[i], req, $sformatf("word %0d", i), 32'(v), 32'(exp_mem[i]));
        end
    endtask

    task automatic finish_erase(int unsigned k0, string req);
        while (cyc < k0 + BUSY_LEN - 1) @(negedge clk);
        check(ry_by_n == 1'b0, req, "busy one cycle before end", 32'(ry_by_n), 0);
        @(negedge clk);
        check(ry_by_n == 1'b1, req, "ready at end", 32'(ry_by_n), 1);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r1, r2;
        int unsigned k0;
        int ms;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = fill(i);

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1: reset state and fill pattern
        check(ry_by_n == 1'b1, "R1", "ready after power-on", 32'(ry_by_n), 1);
        bus_read(BUS_AW'(0), r1);
        check(r1 == fill(0), "R1", "word 0", 32'(r1), 32'(fill(0)));
        bus_read(BUS_AW'(37), r1);
        check(r1 == fill(37), "R1", "word 37", 32'(r1), 32'(fill(37)));
        bus_read(BUS_AW'(DEPTH - 1), r1);
        check(r1 == fill(DEPTH - 1), "R1", "top word", 32'(r1), 32'(fill(DEPTH - 1)));

        // R3: wrong sixth command, then a lone sixth write
        send_steps(0, 4);
        bus_write(BUS_AW'(11'h555), 8'h30);
        repeat (2) @(negedge clk);
        check(ry_by_n == 1'b1, "R3", "wrong final command", 32'(ry_by_n), 1);
        send_steps(5, 5);
        check(ry_by_n == 1'b1, "R3", "lone final after miss", 32'(ry_by_n), 1);
        // R3: wrong second step then rest of chain
        send_steps(0, 0);
        bus_write(BUS_AW'(11'h2AA), 8'hAA);
        send_steps(2, 5);
        check(ry_by_n == 1'b1, "R3", "broken second step", 32'(ry_by_n), 1);

        // R9: hardware reset discards a partial chain
        send_steps(0, 2);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        send_steps(3, 5);
        check(ry_by_n == 1'b1, "R9", "chain cleared by reset", 32'(ry_by_n), 1);

        // R2/R9/R5: start, let ten words preprogram, then abort
        send_steps(0, 5);
        check(ry_by_n == 1'b0, "R2", "busy after sixth write", 32'(ry_by_n), 0);
        repeat (10) @(negedge clk);
        hw_rst_n = 1'b0;
        #1;
        check(ry_by_n == 1'b1, "R9", "ready at once on abort", 32'(ry_by_n), 1);
        @(negedge clk); hw_rst_n = 1'b1;
        for (int i = 0; i < 10; i++) exp_mem[i] = '0;
        check_array("R5 R9");

        // R2/R4/R7/R8: full erase with status polling and ignored writes
        send_steps(0, 5);
        k0 = cyc;
        check(ry_by_n == 1'b0, "R2", "busy after sixth write", 32'(ry_by_n), 0);
        bus_read(BUS_AW'(3), r1);
        bus_read(BUS_AW'(3), r2);
        check(r1[7] == 1'b0 && r2[7] == 1'b0, "R7", "bit 7 low", 32'({r1[7], r2[7]}), 0);
        check(r1[6] != r2[6], "R7", "bit 6 flips", 32'({r1[6], r2[6]}), 32'({r1[6], ~r1[6]}));
        check(r1[2] != r2[2], "R7", "bit 2 flips", 32'({r1[2], r2[2]}), 32'({r1[2], ~r1[2]}));
        check((r1 & ~DW'(16'h0044)) == '0, "R7", "other status bits", 32'(r1), 32'(r1 & DW'(16'h0044)));
        send_steps(0, 4);
        finish_erase(k0, "R4");
        check_array("R6");
        send_steps(5, 5);
        repeat (2) @(negedge clk);
        check(ry_by_n == 1'b1, "R8", "busy writes did not advance chain", 32'(ry_by_n), 1);

        // Random writes against a reference chain model
        ms = 0;
        for (int n = 0; n < 120; n++) begin
            logic [BUS_AW-1:0] a;
            logic [7:0] d;
            bit fire;
            if ($urandom_range(0, 9) < 7) begin
                a = step_addr(ms); d = step_data(ms);
            end else begin
                a = ($urandom_range(0, 1) != 0) ? BUS_AW'(11'h555) : BUS_AW'($urandom);
                case ($urandom_range(0, 4))
                    0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'h80; 3: d = 8'h10;
                    default: d = 8'($urandom);
                endcase
            end
            fire = 1'b0;
            if (a == step_addr(ms) && d == step_data(ms)) begin
                if (ms == 5) begin fire = 1'b1; ms = 0; end
                else ms++;
            end else begin
                ms = 0;
            end
            bus_write(a, d);
            k0 = cyc;
            check(ry_by_n == !fire, "R2 R3", "random write response", 32'(ry_by_n), 32'(!fire));
            if (fire) begin
                finish_erase(k0, "R4");
            end
            if ($urandom_range(0, 3) == 0) begin
                int w;
                w = $urandom_range(0, DEPTH - 1);
                bus_read(BUS_AW'(w), r1);
                check(r1 == exp_mem[w], "R6", "random read", 32'(r1), 32'(exp_mem[w]));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule